// File: doc/BRIEF.md
# Interleaved Cache Bank Predictor

When several cores are aggregated to run one thread, their private L1 data caches form one interleaved cache. Each core's bank owns a fixed slice of the address space, so the combined capacity is the sum of the banks. A memory operation has to be steered to a core before its effective address has been computed. This block guesses the owning bank at steer time from the history of earlier outcomes at the same instruction address.

The steer stage presents a PC and reads back a predicted bank in the same cycle. After address generation, the resolve port supplies the PC, the real address, the bank that was predicted for that operation and its tag. The block works out the real bank from the address and trains its history table. When the operation went to the wrong bank, it issues a one-cycle re-route request carrying the tag and the correct bank. A cross-core re-route costs two cycles of transfer, while an access to the local bank costs nothing, so a wrong guess adds directly to load-to-use latency.

Top module: `bank_predictor`

## Requirements
- R1: After reset every history entry holds bank 0 with confidence 0, `pred_bank_o` reads 0 and `reroute_valid_o` is low.
- R2: `pred_bank_o` gives, in the same cycle and without a clock edge, the bank field of the entry selected by the low 8 bits of `lookup_pc_i`.
- R3: The real bank of a resolved operation is address bits [7:6], which are the two bits just above the 64-byte line offset.
- R4: On a resolve whose real bank equals the bank stored in the selected entry, the confidence rises by one and saturates at 3. The bank is kept.
- R5: On a resolve whose real bank differs from the stored bank while the confidence is non-zero, the confidence drops by one and the stored bank is kept.
- R6: On a resolve whose real bank differs from the stored bank while the confidence is zero, the stored bank is replaced by the real bank and the confidence stays 0.
- R7: In the cycle after a resolve whose real bank differs from `resolve_pred_bank_i`, `reroute_valid_o` is high for that one cycle, with `reroute_tag_o` equal to the resolve tag and `reroute_bank_o` equal to the real bank. Otherwise it is low.
- R8: A lookup and a resolve in the same cycle that select the same entry return the value held before that cycle's update.
- R9: PCs that share their low 8 bits share one entry, so training through one is seen through the other.
- R10: A cycle without a resolve leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | 32 | PC of the memory operation being steered |
| pred_bank_o | output | 2 | Predicted owning bank |
| resolve_valid_i | input | 1 | Resolve strobe after address generation |
| resolve_pc_i | input | 32 | PC of the resolved operation |
| resolve_addr_i | input | 32 | Effective address of the resolved operation |
| resolve_pred_bank_i | input | 2 | Bank the operation was steered to |
| resolve_tag_i | input | 6 | Instruction tag |
| reroute_valid_o | output | 1 | One-cycle re-route request |
| reroute_tag_o | output | 6 | Tag of the operation to re-route |
| reroute_bank_o | output | 2 | Correct bank for the re-route |

## Verification
The properties assume at most one resolve per cycle, which trains one entry. They also assume that the prediction carried back on the resolve port may disagree with the current table contents, because other resolves can retrain the entry in between. The stimulus keeps to one resolve per cycle. It deliberately feeds back stale or arbitrary predicted banks, so the re-route decision and the training decision are exercised apart. Aliased PCs and same-cycle lookup and resolve to one entry are driven on purpose, so that read-before-write ordering is observed at the lookup port.

// File: rtl/bank_pred_pkg.sv
package bank_pred_pkg;
  localparam int unsigned BANK_W = 2;
  localparam int unsigned CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [CONF_W-1:0] conf;
  } hist_entry_t;
endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table
  import bank_pred_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned IdxW = $clog2(ENTRIES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [IdxW-1:0] rd_a_idx_i,
  output hist_entry_t rd_a_o,
  input  logic [IdxW-1:0] rd_b_idx_i,
  output hist_entry_t rd_b_o,
  input  logic        wr_en_i,
  input  logic [IdxW-1:0] wr_idx_i,
  input  hist_entry_t wr_data_i
);
  hist_entry_t mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IdxW'(g))) begin
        mem_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_a_o = mem_q[rd_a_idx_i];
  assign rd_b_o = mem_q[rd_b_idx_i];

  // R4
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (mem_q[$past(rd_a_idx_i)] == $past(rd_a_o)));
endmodule

// File: rtl/bp_train.sv
module bp_train
  import bank_pred_pkg::*;
(
  input  hist_entry_t       old_i,
  input  logic [BANK_W-1:0] actual_i,
  output hist_entry_t       new_o
);
  logic hit;
  assign hit = (old_i.bank == actual_i);

  always_comb begin
    new_o = old_i;
    if (hit) begin
      if (old_i.conf != CONF_MAX) new_o.conf = old_i.conf + 1'b1;
    end else if (old_i.conf != '0) begin
      new_o.conf = old_i.conf - 1'b1;
    end else begin
      new_o.bank = actual_i;
    end
  end
endmodule

// File: rtl/bp_reroute.sv
module bp_reroute
  import bank_pred_pkg::*;
#(
  parameter int unsigned TAG_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BANK_W-1:0] pred_i,
  input  logic [BANK_W-1:0] actual_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [BANK_W-1:0] bank_o
);
  logic miss;
  assign miss = valid_i && (pred_i != actual_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      bank_o  <= '0;
    end else begin
      valid_o <= miss;
      if (miss) begin
        tag_o  <= tag_i;
        bank_o <= actual_i;
      end
    end
  end

  // R7
  reroute_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (pred_i != actual_i)) |=>
      (valid_o && tag_o == $past(tag_i) && bank_o == $past(actual_i)));

  // R7
  reroute_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (pred_i != actual_i)) |=> !valid_o);
endmodule

// File: rtl/bank_predictor.sv
module bank_predictor
  import bank_pred_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned ENTRIES  = 256,
  parameter int unsigned LINE_OFF = 6,
  localparam int unsigned IdxW    = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic [BANK_W-1:0] pred_bank_o,
  input  logic              resolve_valid_i,
  input  logic [PC_W-1:0]   resolve_pc_i,
  input  logic [ADDR_W-1:0] resolve_addr_i,
  input  logic [BANK_W-1:0] resolve_pred_bank_i,
  input  logic [TAG_W-1:0]  resolve_tag_i,
  output logic              reroute_valid_o,
  output logic [TAG_W-1:0]  reroute_tag_o,
  output logic [BANK_W-1:0] reroute_bank_o
);
  logic [IdxW-1:0]   lk_idx, rs_idx;
  logic [BANK_W-1:0] actual_bank;
  hist_entry_t       lk_ent, rs_ent, upd_ent;

  assign lk_idx      = lookup_pc_i[IdxW-1:0];
  assign rs_idx      = resolve_pc_i[IdxW-1:0];
  assign actual_bank = resolve_addr_i[LINE_OFF +: BANK_W];

  bp_hist_table #(.ENTRIES(ENTRIES)) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (lk_idx),
    .rd_a_o     (lk_ent),
    .rd_b_idx_i (rs_idx),
    .rd_b_o     (rs_ent),
    .wr_en_i    (resolve_valid_i),
    .wr_idx_i   (rs_idx),
    .wr_data_i  (upd_ent)
  );

  bp_train i_train (
    .old_i    (rs_ent),
    .actual_i (actual_bank),
    .new_o    (upd_ent)
  );

  bp_reroute #(.TAG_W(TAG_W)) i_reroute (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (resolve_valid_i),
    .pred_i   (resolve_pred_bank_i),
    .actual_i (actual_bank),
    .tag_i    (resolve_tag_i),
    .valid_o  (reroute_valid_o),
    .tag_o    (reroute_tag_o),
    .bank_o   (reroute_bank_o)
  );

  assign pred_bank_o = lk_ent.bank;

  // R4
  sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_valid_i && rs_ent.bank == actual_bank && rs_ent.conf == CONF_MAX)
      |-> (upd_ent.conf == CONF_MAX && upd_ent.bank == rs_ent.bank));

  // R5
  keep_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_valid_i && rs_ent.bank != actual_bank && rs_ent.conf != '0)
      |-> (upd_ent.bank == rs_ent.bank && upd_ent.conf == CONF_W'(rs_ent.conf - 1'b1)));

  // R6
  replace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolve_valid_i && rs_ent.bank != actual_bank && rs_ent.conf == '0)
      |-> (upd_ent.bank == actual_bank && upd_ent.conf == '0));
endmodule

// File: tb/test_bank_predictor.sv
module test_bank_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lookup_pc_i = '0;
  logic [1:0]  pred_bank_o;
  logic        resolve_valid_i = 1'b0;
  logic [31:0] resolve_pc_i = '0;
  logic [31:0] resolve_addr_i = '0;
  logic [1:0]  resolve_pred_bank_i = '0;
  logic [5:0]  resolve_tag_i = '0;
  logic        reroute_valid_o;
  logic [5:0]  reroute_tag_o;
  logic [1:0]  reroute_bank_o;

  int checks = 0;
  int errors = 0;
  int mb[256];
  int mc[256];
  logic       exp_rv = 1'b0;
  logic [5:0] exp_rt = '0;
  logic [1:0] exp_rb = '0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bank_predictor i_bank_predictor (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lookup_pc_i(lookup_pc_i), .pred_bank_o(pred_bank_o),
    .resolve_valid_i(resolve_valid_i), .resolve_pc_i(resolve_pc_i),
    .resolve_addr_i(resolve_addr_i), .resolve_pred_bank_i(resolve_pred_bank_i),
    .resolve_tag_i(resolve_tag_i), .reroute_valid_o(reroute_valid_o),
    .reroute_tag_o(reroute_tag_o), .reroute_bank_o(reroute_bank_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: check last reroute, drive, check lookup, advance model
  task automatic step(input logic [31:0] lpc, input bit rv, input logic [31:0] rpc,
                      input logic [1:0] bank, input logic [1:0] rpred, input logic [5:0] rtag);
    int li, ri, act;
    @(negedge clk_i);
    chk(reroute_valid_o === exp_rv, "R7 valid", int'(reroute_valid_o), int'(exp_rv));
    if (exp_rv) begin
      chk(reroute_tag_o == exp_rt, "R7 tag", int'(reroute_tag_o), int'(exp_rt));
      chk(reroute_bank_o == exp_rb, "R7 bank", int'(reroute_bank_o), int'(exp_rb));
    end
    lookup_pc_i         = lpc;
    resolve_valid_i     = rv;
    resolve_pc_i        = rpc;
    resolve_addr_i      = {$urandom} & 32'hFFFF_FF3F | (32'(bank) << 6); // R3 bank in [7:6]
    resolve_pred_bank_i = rpred;
    resolve_tag_i       = rtag;
    #1;
    li = int'(lpc[7:0]);
    ri = int'(rpc[7:0]);
    if (rv && li == ri)
      chk(pred_bank_o == 2'(mb[li]), "R8 lookup", int'(pred_bank_o), mb[li]);
    else
      chk(pred_bank_o == 2'(mb[li]), "R2 lookup", int'(pred_bank_o), mb[li]);
    exp_rv = 1'b0;
    if (rv) begin
      act = int'(bank);
      if (mb[ri] == act) begin
        if (mc[ri] < 3) mc[ri]++;
      end else if (mc[ri] > 0) begin
        mc[ri]--;
      end else begin
        mb[ri] = act;
      end
      if (rpred != bank) begin
        exp_rv = 1'b1;
        exp_rt = rtag;
        exp_rb = bank;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb;
    for (int i = 0; i < 256; i++) begin mb[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(reroute_valid_o == 1'b0, "R1 reroute", int'(reroute_valid_o), 0);
    for (int i = 0; i < 256; i += 37) begin
      lookup_pc_i = 32'(i); #1;
      chk(pred_bank_o == 2'd0, "R1 entry", int'(pred_bank_o), 0);
    end

    pa = 32'h0000_0110;
    pb = 32'h0000_2210; // R9 alias of pa
    // R6 replace at zero confidence, R7 reroute with wrong pred
    step(pa, 1, pa, 2'd2, 2'd0, 6'd5);
    step(pa, 0, pa, 2'd0, 2'd0, 6'd0);
    // R4 climb to saturation and beyond, correct pred, no reroute
    for (int k = 0; k < 5; k++) step(pb, 1, pa, 2'd2, 2'd2, 6'(k));
    // R5 wrong outcomes drain confidence, bank kept for three, replaced on fourth
    for (int k = 0; k < 5; k++) step(pa, 1, pb, 2'd1, 2'd2, 6'(10 + k));
    // R10 idle cycles
    for (int k = 0; k < 4; k++) step(pb, 0, pa, 2'd3, 2'd0, 6'd0);
    // R8 same-cycle lookup and resolve
    step(pa, 1, pa, 2'd3, 2'd3, 6'd21);
    step(pa, 1, pa, 2'd3, 2'd1, 6'd22);
    // back-to-back reroutes R7
    step(32'h40, 1, 32'h41, 2'd3, 2'd0, 6'd30);
    step(32'h41, 1, 32'h42, 2'd1, 2'd2, 6'd31);
    step(32'h42, 0, 32'h42, 2'd0, 2'd0, 6'd0);

    // mixed traffic over a small PC set with biased banks
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] l, r;
      logic [1:0] b;
      l = 32'($urandom_range(0, 7)) << (($urandom_range(0, 1) == 1) ? 8 : 0);
      r = 32'($urandom_range(0, 7)) | (32'($urandom_range(0, 3)) << 12);
      b = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'(r[1:0]);
      step(l, $urandom_range(0, 3) != 0, r, b, 2'($urandom), 6'($urandom));
    end
    step(32'h0, 0, 32'h0, 2'd0, 2'd0, 6'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule